// File: doc/BRIEF.md
# DMA Paged Address Generator

This block turns the programming of one DMA channel into a stream of physical memory addresses. Software loads a 16-bit start address, a 16-bit transfer count, a page byte, an optional high page byte and three mode bits. After the load, every transfer strobe produces the physical address and byte-lane enables for that transfer. The block then steps the live address and count.

The upper address bits come from the page registers, and the counter never carries into them. A run that passes the top of its window therefore wraps back to the bottom of the same window. Byte channels use a 64 KB window. Word channels use a 128 KB window: the whole mapping moves up by one bit and page bit 0 drops out. When the count runs out, a terminal-count pulse marks the last transfer. The channel then either stops, or reloads its base values and keeps running.

Top module: `dma_paged_addr_gen`

## Requirements
- R1: After synchronous reset, the live address and the live count are 0, terminal count is low, and transfer strobes have no effect until the first load.
- R2: A load copies the base address, base count, page bytes and mode bits into the channel and arms it. The live values equal the base values on the next cycle, even if a strobe arrives in the same cycle as the load.
- R3: In byte mode (`mode_word_i`=0), the physical address is {high page, page, live address}. It shows the value used by the current transfer, before that transfer's update.
- R4: In word mode (`mode_word_i`=1), the physical address is {high page, page[7:1], live address, 1'b0}. Page bit 0 has no effect.
- R5: Each accepted strobe moves the live address up by one, or down by one when `mode_down_i`=1. The address wraps modulo 65536, and bits above the window never change between loads.
- R6: Each accepted strobe lowers the live count by one. A programmed count N gives N+1 transfers, so 0x0000 gives one transfer and 0xFFFF gives 65536.
- R7: `tc_o` is high during exactly the strobe cycle whose live count is 0.
- R8: Without autoinit (`mode_auto_i`=0), the terminal transfer still steps the address and the count, the count wrapping to 0xFFFF. After that, strobes leave the live address and count unchanged until the next load.
- R9: With autoinit (`mode_auto_i`=1), the terminal transfer reloads the live address and count from the base values, and the channel stays armed.
- R10: In word mode `byte_en_o` is 2'b11. In byte mode it is 2'b01 when live address bit 0 is 0 and 2'b10 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for base values, pages and mode |
| base_addr_i | input | 16 | Start address |
| base_count_i | input | 16 | Transfers minus one |
| page_i | input | 8 | Page byte |
| page_hi_i | input | 8 | High page byte, physical bits 31:24 |
| mode_word_i | input | 1 | 1 = word channel |
| mode_auto_i | input | 1 | 1 = reload at terminal count |
| mode_down_i | input | 1 | 1 = address decrements |
| xfer_i | input | 1 | Transfer strobe |
| phys_addr_o | output | 32 | Physical address of the current transfer |
| byte_en_o | output | 2 | Byte-lane enables |
| tc_o | output | 1 | Terminal-count pulse |
| cur_addr_o | output | 16 | Live address |
| cur_count_o | output | 16 | Live count |

## Verification
The bench uses the default parameters: a full 16-bit counter, an 8-bit page and the high page enabled. With the full counter width, the 65536-transfer run and the wraps at 0xFFFF and 0x0000 in both directions are reachable. With the high page enabled, the full 32-bit physical address is compared. A behavioural model is compared with every output on every cycle. Directed checks cover the stop after terminal count, the autoinit reload and a load that collides with a strobe.

// File: rtl/dma_pag_pkg.sv
package dma_pag_pkg;

    typedef struct packed {
        logic word;
        logic autoinit;
        logic down;
    } xfer_mode_t;

    function automatic logic [1:0] lane_sel(input logic word, input logic a0);
        if (word) return 2'b11;
        return a0 ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dma_pag_chan.sv
module dma_pag_chan
    import dma_pag_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   base_addr_i,
    input  logic [CNT_W-1:0]   base_count_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [HPAGE_W-1:0] hpage_i,
    input  xfer_mode_t         mode_i,
    input  logic               xfer_i,
    output logic [CNT_W-1:0]   cur_addr_o,
    output logic [CNT_W-1:0]   cur_count_o,
    output logic [PAGE_W-1:0]  page_o,
    output logic [HPAGE_W-1:0] hpage_o,
    output xfer_mode_t         mode_o,
    output logic               tc_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
    logic             armed_q;
    logic             take;
    logic             last;

    assign take = xfer_i && armed_q && !load_i;
    assign last = (cur_cnt_q == '0);
    assign tc_o = take && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr_q <= '0;
            base_cnt_q  <= '0;
            cur_addr_q  <= '0;
            cur_cnt_q   <= '0;
            page_o      <= '0;
            hpage_o     <= '0;
            mode_o      <= '0;
            armed_q     <= 1'b0;
        end else if (load_i) begin
            base_addr_q <= base_addr_i;
            base_cnt_q  <= base_count_i;
            cur_addr_q  <= base_addr_i;
            cur_cnt_q   <= base_count_i;
            page_o      <= page_i;
            hpage_o     <= hpage_i;
            mode_o      <= mode_i;
            armed_q     <= 1'b1;
        end else if (take) begin
            if (last && mode_o.autoinit) begin
                cur_addr_q <= base_addr_q;
                cur_cnt_q  <= base_cnt_q;
            end else begin
                cur_addr_q <= mode_o.down ? cur_addr_q - ONE : cur_addr_q + ONE;
                cur_cnt_q  <= cur_cnt_q - ONE;
                if (last) armed_q <= 1'b0;
            end
        end
    end

    assign cur_addr_o  = cur_addr_q;
    assign cur_count_o = cur_cnt_q;

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cur_addr_q == $past(base_addr_i)) && (cur_cnt_q == $past(base_count_i)));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && armed_q && !load_i && !(last && mode_o.autoinit))
        |=> cur_cnt_q == $past(cur_cnt_q) - ONE);

    // R8
    stop_after_tc_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_o && !mode_o.autoinit) |=> !armed_q);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !load_i) |=> $stable(cur_addr_q) && $stable(cur_cnt_q));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_o && mode_o.autoinit) |=> (cur_addr_q == base_addr_q) && (cur_cnt_q == base_cnt_q) && armed_q);

endmodule

// File: rtl/dma_pag_map.sv
module dma_pag_map
    import dma_pag_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 8,
    parameter bit HIGH_EN = 1'b1,
    parameter int PHYS_W  = HPAGE_W + PAGE_W + CNT_W
) (
    input  logic [CNT_W-1:0]   cur_addr_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [HPAGE_W-1:0] hpage_i,
    input  logic               word_i,
    output logic [PHYS_W-1:0]  phys_o,
    output logic [1:0]         be_o
);
    localparam int LOW_W = PAGE_W + CNT_W;

    logic [HPAGE_W-1:0] hp_eff;
    logic [LOW_W-1:0]   low;

    generate
        if (HIGH_EN) begin : g_hpage
            assign hp_eff = hpage_i;
        end else begin : g_no_hpage
            assign hp_eff = '0;
        end
    endgenerate

    always_comb begin
        if (word_i) low = {page_i[PAGE_W-1:1], cur_addr_i, 1'b0};
        else        low = {page_i, cur_addr_i};
    end

    assign phys_o = {hp_eff, low};
    assign be_o   = lane_sel(word_i, cur_addr_i[0]);

endmodule

// File: rtl/dma_paged_addr_gen.sv
module dma_paged_addr_gen
    import dma_pag_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PAGE_W  = 8,
    parameter int HPAGE_W = 8,
    parameter bit HIGH_EN = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_i,
    input  logic [CNT_W-1:0]                  base_addr_i,
    input  logic [CNT_W-1:0]                  base_count_i,
    input  logic [PAGE_W-1:0]                 page_i,
    input  logic [HPAGE_W-1:0]                page_hi_i,
    input  logic                              mode_word_i,
    input  logic                              mode_auto_i,
    input  logic                              mode_down_i,
    input  logic                              xfer_i,
    output logic [HPAGE_W+PAGE_W+CNT_W-1:0]   phys_addr_o,
    output logic [1:0]                        byte_en_o,
    output logic                              tc_o,
    output logic [CNT_W-1:0]                  cur_addr_o,
    output logic [CNT_W-1:0]                  cur_count_o
);
    localparam int PHYS_W = HPAGE_W + PAGE_W + CNT_W;

    xfer_mode_t         mode_in, mode_q;
    logic [PAGE_W-1:0]  page_q;
    logic [HPAGE_W-1:0] hpage_q;

    assign mode_in = '{word: mode_word_i, autoinit: mode_auto_i, down: mode_down_i};

    dma_pag_chan #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W)) u_chan (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .base_addr_i  (base_addr_i),
        .base_count_i (base_count_i),
        .page_i       (page_i),
        .hpage_i      (page_hi_i),
        .mode_i       (mode_in),
        .xfer_i       (xfer_i),
        .cur_addr_o   (cur_addr_o),
        .cur_count_o  (cur_count_o),
        .page_o       (page_q),
        .hpage_o      (hpage_q),
        .mode_o       (mode_q),
        .tc_o         (tc_o)
    );

    dma_pag_map #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W),
                  .HIGH_EN(HIGH_EN), .PHYS_W(PHYS_W)) u_map (
        .cur_addr_i (cur_addr_o),
        .page_i     (page_q),
        .hpage_i    (hpage_q),
        .word_i     (mode_q.word),
        .phys_o     (phys_addr_o),
        .be_o       (byte_en_o)
    );

    // R5
    page_window_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(phys_addr_o[PHYS_W-1:CNT_W+1]));

    // R10
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q.word |-> $onehot(byte_en_o));

    // R1
    idle_tc_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_i |-> !tc_o);

endmodule

// File: tb/dma_paged_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_paged_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [15:0] base_addr_i = '0, base_count_i = '0;
    logic [7:0]  page_i = '0, page_hi_i = '0;
    logic        mode_word_i = 1'b0, mode_auto_i = 1'b0, mode_down_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic [31:0] phys_addr_o;
    logic [1:0]  byte_en_o;
    logic        tc_o;
    logic [15:0] cur_addr_o, cur_count_o;

    int n_cmp = 0;
    int n_bad = 0;
    int tc_seen = 0;

    // behavioural model state
    int unsigned m_addr, m_cnt, m_ba, m_bc, m_pg, m_hp;
    bit m_word, m_auto, m_down, m_armed;

    always #10 clk = ~clk;

    dma_paged_addr_gen u_dma_paged_addr_gen (
        .clk(clk), .rst(rst), .load_i(load_i), .base_addr_i(base_addr_i),
        .base_count_i(base_count_i), .page_i(page_i), .page_hi_i(page_hi_i),
        .mode_word_i(mode_word_i), .mode_auto_i(mode_auto_i), .mode_down_i(mode_down_i),
        .xfer_i(xfer_i), .phys_addr_o(phys_addr_o), .byte_en_o(byte_en_o), .tc_o(tc_o),
        .cur_addr_o(cur_addr_o), .cur_count_o(cur_count_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_phys();
        if (m_word) return (m_hp << 24) | ((m_pg >> 1) << 17) | (m_addr << 1);
        return (m_hp << 24) | (m_pg << 16) | m_addr;
    endfunction

    // compare on every clock, then advance the model to what the next edge does
    always @(negedge clk) begin
        if (rst) begin
            m_addr = 0; m_cnt = 0; m_ba = 0; m_bc = 0; m_pg = 0; m_hp = 0;
            m_word = 0; m_auto = 0; m_down = 0; m_armed = 0;
        end else begin
            bit t;
            t = !load_i && xfer_i && m_armed && (m_cnt == 0);
            check(m_word ? "R4 phys" : "R3 phys", phys_addr_o, exp_phys());
            check("R10 byte_en", 32'(byte_en_o), m_word ? 32'd3 : ((m_addr & 1) != 0 ? 32'd2 : 32'd1));
            check("R7 tc", 32'(tc_o), 32'(t));
            check("R5 cur_addr", 32'(cur_addr_o), m_addr);
            check("R6 cur_count", 32'(cur_count_o), m_cnt);
            if (tc_o) tc_seen++;
            if (load_i) begin
                m_ba = base_addr_i; m_bc = base_count_i; m_addr = base_addr_i; m_cnt = base_count_i;
                m_pg = page_i; m_hp = page_hi_i;
                m_word = mode_word_i; m_auto = mode_auto_i; m_down = mode_down_i; m_armed = 1;
            end else if (xfer_i && m_armed) begin
                if (m_cnt == 0 && m_auto) begin
                    m_addr = m_ba; m_cnt = m_bc;
                end else begin
                    if (m_cnt == 0) m_armed = 0;
                    m_addr = (m_down ? m_addr - 1 : m_addr + 1) & 32'hFFFF;
                    m_cnt  = (m_cnt - 1) & 32'hFFFF;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                           input logic [7:0] h, input bit w, input bit au, input bit dn, input bit x);
        base_addr_i = a; base_count_i = c; page_i = p; page_hi_i = h;
        mode_word_i = w; mode_auto_i = au; mode_down_i = dn;
        load_i = 1'b1; xfer_i = x;
        tick();
        load_i = 1'b0; xfer_i = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_i = 1'b1; tick();
        end
        xfer_i = 1'b0;
    endtask

    initial begin
        #(190000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();
        // R1: reset state, strobes ignored before any load
        check("R1 addr", 32'(cur_addr_o), 0);
        check("R1 count", 32'(cur_count_o), 0);
        strobes(3);
        check("R1 held", 32'(cur_count_o), 0);

        // byte mode, increment across 0xFFFF, four transfers then stop
        do_load(16'hFFFE, 16'd3, 8'h12, 8'hA5, 0, 0, 0, 0);
        check("R2 load addr", 32'(cur_addr_o), 32'hFFFE);
        strobes(4);
        check("R5 wrap", 32'(cur_addr_o), 32'h0002);
        check("R5 page kept", 32'(phys_addr_o[31:16]), 32'hA512);
        check("R8 count wrapped", 32'(cur_count_o), 32'hFFFF);
        strobes(3);
        check("R8 addr hold", 32'(cur_addr_o), 32'h0002);

        // word mode, decrement across 0x0000, odd page
        do_load(16'h0001, 16'd4, 8'h35, 8'hA5, 1, 0, 1, 0);
        xfer_i = 1'b1;
        @(negedge clk);
        check("R4 first", phys_addr_o, 32'hA5340002);
        tick(); tick();
        @(negedge clk);
        check("R4 window", phys_addr_o, 32'hA535FFFE);
        check("R10 word lanes", 32'(byte_en_o), 32'd3);
        tick(); tick(); tick();
        xfer_i = 1'b0;
        check("R5 down", 32'(cur_addr_o), 32'hFFFC);

        // autoinit, gapped strobes
        tc_seen = 0;
        do_load(16'h1000, 16'd2, 8'h00, 8'h00, 0, 1, 0, 0);
        for (int i = 0; i < 7; i++) begin
            xfer_i = 1'b1; tick();
            xfer_i = 1'b0; tick();
        end
        check("R9 tc pulses", tc_seen, 2);
        check("R9 addr", 32'(cur_addr_o), 32'h1001);
        check("R9 count", 32'(cur_count_o), 32'd1);

        // load colliding with a strobe
        do_load(16'h4444, 16'h0010, 8'h01, 8'h02, 0, 0, 0, 1);
        check("R2 collide count", 32'(cur_count_o), 32'h0010);
        check("R2 collide addr", 32'(cur_addr_o), 32'h4444);

        // count zero: one transfer
        do_load(16'h0100, 16'h0000, 8'h00, 8'h00, 0, 0, 0, 0);
        xfer_i = 1'b1;
        @(negedge clk);
        check("R6 single tc", 32'(tc_o), 1);
        tick(); xfer_i = 1'b0;
        strobes(2);
        check("R6 single addr", 32'(cur_addr_o), 32'h0101);

        // maximum count: 65536 transfers
        do_load(16'h8000, 16'hFFFF, 8'h07, 8'h00, 0, 0, 0, 0);
        begin
            int n = 0;
            xfer_i = 1'b1;
            while (1) begin
                @(negedge clk);
                n++;
                if (tc_o || n > 70000) break;
            end
            tick();
            xfer_i = 1'b0;
            check("R6 max transfers", n, 65536);
        end
        check("R5 full wrap", 32'(cur_addr_o), 32'h8000);
        strobes(2);
        check("R8 after max", 32'(cur_count_o), 32'hFFFF);

        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule